// File: doc/BRIEF.md
# SPI Select-Line Management Controller

This block is the select-line and role logic that sits next to an SPI shift engine. It takes the peripheral's control bits as they are written by software, and it holds them. It then decides three things: whether the shared active-low select pin is driven or sensed, which level it carries, and whether the peripheral is currently a master or a slave. It also gives the shift engine an active-high "selected" signal that gates slave-mode shifting.

There are three ways to manage the select line:
- **Software management.** An internal select bit stands in for the pin, and the pin is left free.
- **Hardware output.** A master drives the pin low for as long as it is enabled. Optionally, it inserts a one-SPI-clock high pulse between back-to-back frames.
- **Hardware input.** The pin is sensed. A master that sees the pin pulled low by another device records a sticky mode fault. It then demotes itself to slave and is forced disabled until software clears the fault.

The shift engine supplies three strobes: a frame-boundary strobe, a "another frame follows at once" qualifier, and a tick once per SPI clock period. The sensed pin passes through a synchronizer before it is used.

Top module: `spi_sel_ctrl`

## Requirements
- R1: Out of reset the block is a disabled slave: `master_o`=0, `enable_o`=0, `fault_o`=0, `ss_pin_oe`=0, `ss_pin_o`=1 and `slave_sel`=0.
- R2: With `cfg_swsel`=1 the effective select level is `cfg_isel`, and the pin input has no effect. A slave is selected when `cfg_isel`=0 and deselected when `cfg_isel`=1, whatever the pin does.
- R3: A master with `cfg_swsel`=0 and `cfg_drive`=1 drives the pin (`ss_pin_oe`=1). It drives 0 while enabled and 1 while disabled.
- R4: In hardware output mode with `cfg_pulse`=1, a `frame_end` strobe together with `frame_more`=1 makes the pin go high at the next `sck_tick`. The pin stays high until the following `sck_tick`, so it is high for exactly one SPI clock period.
- R5: A `frame_end` strobe with `frame_more`=0 (the final frame) produces no pulse.
- R6: An enabled master with `cfg_swsel`=0 and `cfg_drive`=0 leaves the pin undriven. A low level on the pin, once synchronized, sets `fault_o`.
- R7: When a fault is set, the master bit and the enable bit are cleared. While the fault stays set, a register write cannot set the enable bit.
- R8: The fault is cleared only by a register write that comes after a `stat_rd` strobe made while the fault was set. That write takes effect with its enable value.
- R9: An enabled master in software mode with `cfg_isel`=0 is demoted to slave and records a fault.
- R10: The pin is never driven in slave mode. `slave_sel` is 1 only when the block is enabled, is a slave, and has an effective select level of 0.
- R11: An enabled master in software mode with `cfg_isel`=1 ignores a low pin and stays a master without a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe, loads the cfg_* bits |
| cfg_en | input | 1 | Peripheral enable |
| cfg_master | input | 1 | Master role request |
| cfg_swsel | input | 1 | Software select management |
| cfg_isel | input | 1 | Internal select level used in software management |
| cfg_drive | input | 1 | Select-pin output enable in hardware management |
| cfg_pulse | input | 1 | Inter-frame pulse enable |
| stat_rd | input | 1 | Status read strobe, first half of the fault clear sequence |
| frame_end | input | 1 | Frame boundary strobe from the shift engine |
| frame_more | input | 1 | Another frame follows with no idle gap |
| sck_tick | input | 1 | One strobe per SPI clock period |
| ss_pin_i | input | 1 | Select pin input level |
| ss_pin_o | output | 1 | Select pin output level |
| ss_pin_oe | output | 1 | Select pin output enable |
| slave_sel | output | 1 | Active-high slave-selected gate for the shift engine |
| master_o | output | 1 | Current master bit |
| enable_o | output | 1 | Current enable bit |
| fault_o | output | 1 | Sticky mode fault |

## Verification
The bench builds the block with a two-stage pin synchronizer (`SYNC_STAGES`=2). It therefore waits out that latency before it judges any pin-driven outcome, such as a fault or a slave selection. SPI clock ticks are supplied every fourth system clock. This makes a one-period pulse four cycles wide, so a pulse that is one cycle too short or too long is caught by counting high samples.

// File: rtl/ssm_pkg.sv
// Package: shared types for the select-line management controller.
// Assumes nothing beyond the control bits listed in the struct.
package ssm_pkg;

    // Held control register contents
    typedef struct packed {
        logic en;
        logic master;
        logic swsel;
        logic isel;
        logic drive;
        logic pulse;
    } ssm_cfg_t;

    // Select-line management mode derived from the control bits
    typedef enum logic [1:0] {
        SEL_SOFT   = 2'd0,
        SEL_HW_OUT = 2'd1,
        SEL_HW_IN  = 2'd2
    } sel_mode_e;

    function automatic sel_mode_e sel_mode(input logic swsel, input logic drive);
        if (swsel)      return SEL_SOFT;
        else if (drive) return SEL_HW_OUT;
        else            return SEL_HW_IN;
    endfunction

endpackage

// File: rtl/ssm_cfg_reg.sv
// Module: control register holder with sticky mode fault.
// Loads the control bits on a write. On a fault request it clears the
// master and enable bits and sets the fault flag. The fault is cleared
// by a status read followed by a write. Assumes fault_req is registered
// state derived logic, valid every cycle.
module ssm_cfg_reg
    import ssm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  ssm_cfg_t wr_cfg,
    input  logic     rd,
    input  logic     fault_req,
    output ssm_cfg_t cfg_q,
    output logic     fault_q
);

    logic armed_q;

    // Register update: fault has priority over a write, a write over arming
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            fault_q <= 1'b0;
            armed_q <= 1'b0;
        end else if (fault_req) begin
            fault_q       <= 1'b1;
            cfg_q.master  <= 1'b0;
            cfg_q.en      <= 1'b0;
            armed_q       <= 1'b0;
        end else if (wr) begin
            cfg_q   <= wr_cfg;
            armed_q <= 1'b0;
            if (fault_q && !armed_q) cfg_q.en <= 1'b0;
            if (fault_q && armed_q)  fault_q  <= 1'b0;
        end else if (rd && fault_q) begin
            armed_q <= 1'b1;
        end
    end

    // R7
    fault_blocks_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q |-> !cfg_q.en);

    // R7
    fault_demotes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_q) |-> !cfg_q.master);

    // R8
    fault_clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_q) |-> $past(wr));

endmodule

// File: rtl/ssm_sel_resolve.sv
// Module: select-level resolver and fault detector.
// Synchronizes the pin and selects the effective select level for the
// current mode. Raises a fault request for a master that loses the bus,
// and produces the slave-selected gate. Assumes the pin is asynchronous
// to clk.
module ssm_sel_resolve
    import ssm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic master,
    input  logic swsel,
    input  logic isel,
    input  logic drive,
    input  logic pin_i,
    output logic fault_req,
    output logic slave_sel
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    sel_mode_e mode;
    logic      eff_sel_n;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            // Synchronizer stage s, resets to the deselected (high) level
            always_ff @(posedge clk) begin
                if (!rst_n)      sync_q[s] <= 1'b1;
                else if (s == 0) sync_q[s] <= pin_i;
                else             sync_q[s] <= sync_q[(s > 0) ? s - 1 : 0];
            end
        end
    endgenerate

    // Effective select level and fault request for the current mode
    always_comb begin
        mode      = sel_mode(swsel, drive);
        eff_sel_n = 1'b1;
        fault_req = 1'b0;
        unique case (mode)
            SEL_SOFT: begin
                eff_sel_n = isel;
                fault_req = en && master && !isel;
            end
            SEL_HW_IN: begin
                eff_sel_n = sync_q[LAST];
                fault_req = en && master && !sync_q[LAST];
            end
            default: begin
                eff_sel_n = master ? !en : sync_q[LAST];
            end
        endcase
        slave_sel = en && !master && !eff_sel_n;
    end

    // R10
    slave_sel_only_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slave_sel |-> (!master && en));

    // R11
    soft_high_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swsel && isel) |-> !fault_req);

endmodule

// File: rtl/ssm_pin_drv.sv
// Module: select-pin driver with inter-frame pulse.
// Drives the pin only for a master in hardware output mode: low while
// enabled, high while disabled. In pulse mode it raises the pin for one
// SPI clock period between back-to-back frames. Assumes sck_tick is a
// single-cycle strobe once per SPI clock period.
module ssm_pin_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic out_act,
    input  logic en,
    input  logic pulse_mode,
    input  logic frame_end,
    input  logic frame_more,
    input  logic sck_tick,
    output logic pin_o,
    output logic pin_oe
);

    logic pend_q;
    logic hi_q;

    // Pulse sequencer: arm at a boundary, rise at next tick, fall at the one after
    always_ff @(posedge clk) begin
        if (!rst_n || !out_act || !en) begin
            pend_q <= 1'b0;
            hi_q   <= 1'b0;
        end else begin
            if (frame_end && frame_more && pulse_mode) pend_q <= 1'b1;
            if (sck_tick) begin
                if (hi_q) begin
                    hi_q <= 1'b0;
                end else if (pend_q) begin
                    hi_q   <= 1'b1;
                    pend_q <= 1'b0;
                end
            end
        end
    end

    // Pin level and output enable
    always_comb begin
        pin_oe = out_act;
        pin_o  = out_act ? (!en || hi_q) : 1'b1;
    end

    // R3
    drive_high_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && !en) |-> pin_o);

    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hi_q) && !sck_tick && en && out_act) |=> hi_q);

    // R10
    undriven_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> pin_o);

endmodule

// File: rtl/spi_sel_ctrl.sv
// Module: top of the select-line management controller.
// Ties together the control register holder, the select resolver and the
// pin driver. Assumes the shift engine provides frame_end, frame_more and
// sck_tick in the clk domain.
module spi_sel_ctrl
    import ssm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_en,
    input  logic cfg_master,
    input  logic cfg_swsel,
    input  logic cfg_isel,
    input  logic cfg_drive,
    input  logic cfg_pulse,
    input  logic stat_rd,
    input  logic frame_end,
    input  logic frame_more,
    input  logic sck_tick,
    input  logic ss_pin_i,
    output logic ss_pin_o,
    output logic ss_pin_oe,
    output logic slave_sel,
    output logic master_o,
    output logic enable_o,
    output logic fault_o
);

    ssm_cfg_t wr_cfg;
    ssm_cfg_t cfg_q;
    logic     fault_req;
    logic     out_act;

    // Pack the write data and decide whether the pin is an output
    always_comb begin
        wr_cfg  = '{en: cfg_en, master: cfg_master, swsel: cfg_swsel,
                    isel: cfg_isel, drive: cfg_drive, pulse: cfg_pulse};
        out_act = cfg_q.master && (sel_mode(cfg_q.swsel, cfg_q.drive) == SEL_HW_OUT);
    end

    ssm_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .wr_cfg    (wr_cfg),
        .rd        (stat_rd),
        .fault_req (fault_req),
        .cfg_q     (cfg_q),
        .fault_q   (fault_o)
    );

    ssm_sel_resolve #(.SYNC_STAGES(SYNC_STAGES)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_q.en),
        .master    (cfg_q.master),
        .swsel     (cfg_q.swsel),
        .isel      (cfg_q.isel),
        .drive     (cfg_q.drive),
        .pin_i     (ss_pin_i),
        .fault_req (fault_req),
        .slave_sel (slave_sel)
    );

    ssm_pin_drv u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .out_act    (out_act),
        .en         (cfg_q.en),
        .pulse_mode (cfg_q.pulse),
        .frame_end  (frame_end),
        .frame_more (frame_more),
        .sck_tick   (sck_tick),
        .pin_o      (ss_pin_o),
        .pin_oe     (ss_pin_oe)
    );

    assign master_o = cfg_q.master;
    assign enable_o = cfg_q.en;

    // R10
    slave_never_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_o |-> !ss_pin_oe);

    // R6
    hw_in_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_o && !cfg_q.swsel && !cfg_q.drive) |-> !ss_pin_oe);

endmodule

// File: tb/sim_spi_sel_ctrl.sv
module sim_spi_sel_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 0, cfg_en = 0, cfg_master = 0, cfg_swsel = 0, cfg_isel = 0;
    logic cfg_drive = 0, cfg_pulse = 0, stat_rd = 0;
    logic frame_end = 0, frame_more = 0, sck_tick = 0, ss_pin_i = 1;
    logic ss_pin_o, ss_pin_oe, slave_sel, master_o, enable_o, fault_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    spi_sel_ctrl #(.SYNC_STAGES(2)) u0 (.*);

    // Row: {en,master,swsel,isel,drive,pulse,pin | oe,out,ss,master,fault}
    localparam int NROWS = 9;
    localparam logic [11:0] TABLE [NROWS] = '{
        12'b1000000_01100, // R10 slave hw, pin low -> selected
        12'b1000001_01000, // R10 slave hw, pin high -> not selected
        12'b1010001_01100, // R2 slave sw isel=0, pin high ignored
        12'b1011000_01000, // R2 slave sw isel=1, pin low ignored
        12'b1100101_10010, // R3 master hw out enabled -> low
        12'b0100101_11010, // R3 master hw out disabled -> high
        12'b1100001_01010, // R6 master hw in, pin high -> no fault
        12'b1111000_01010, // R11 master sw isel=1, pin low ignored
        12'b0000000_01000  // R10 disabled slave, pin low -> not selected
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic e, m, s, i, d, p);
        @(negedge clk);
        {cfg_en, cfg_master, cfg_swsel, cfg_isel, cfg_drive, cfg_pulse} = {e, m, s, i, d, p};
        cfg_wr = 1;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    // Count high samples of the pin over 12 cycles with a tick every 4th cycle
    task automatic pulse_run(input logic more, output int highs);
        highs = 0;
        @(negedge clk);
        frame_end = 1; frame_more = more;
        @(negedge clk);
        frame_end = 0; frame_more = 0;
        cyc(1);
        for (int i = 0; i < 12; i++) begin
            sck_tick = (i % 4 == 0);
            @(negedge clk);
            sck_tick = 0;
            if (ss_pin_o) highs++;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int highs;
        cyc(3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset", {master_o, enable_o, fault_o, ss_pin_oe, ss_pin_o, slave_sel}, 6'b000010);

        for (int r = 0; r < NROWS; r++) begin
            wr(TABLE[r][11], TABLE[r][10], TABLE[r][9], TABLE[r][8], TABLE[r][7], TABLE[r][6]);
            ss_pin_i = TABLE[r][5];
            cyc(4);
            chk($sformatf("R2/R3/R6/R10/R11 row %0d", r),
                {ss_pin_oe, ss_pin_o, slave_sel, master_o, fault_o}, TABLE[r][4:0]);
        end

        // R4 pulse: one SPI period = 4 cycles high
        ss_pin_i = 1;
        wr(1, 1, 0, 0, 1, 1);
        cyc(2);
        chk("R4 low before pulse", ss_pin_o, 0);
        pulse_run(1, highs);
        chk("R4 pulse width", highs, 4);
        // R5 final frame: no pulse
        pulse_run(0, highs);
        chk("R5 no pulse after final frame", highs, 0);

        // R6 / R7 fault in hardware input mode
        wr(1, 1, 0, 0, 0, 0);
        ss_pin_i = 0;
        cyc(4);
        chk("R6 fault on low pin", fault_o, 1);
        chk("R7 demoted/disabled", {master_o, enable_o}, 2'b00);
        ss_pin_i = 1;
        cyc(3);
        wr(1, 1, 0, 0, 0, 0);
        cyc(1);
        chk("R7 write cannot enable", {enable_o, fault_o}, 2'b01);
        // R8 read then write clears
        @(negedge clk); stat_rd = 1;
        @(negedge clk); stat_rd = 0;
        wr(1, 1, 0, 0, 0, 0);
        cyc(1);
        chk("R8 fault cleared", {fault_o, enable_o, master_o}, 3'b011);

        // R9 software master with internal select low
        wr(1, 1, 1, 0, 0, 0);
        cyc(2);
        chk("R9 sw demotion", {fault_o, master_o, enable_o}, 3'b100);
        chk("R10 no drive after demotion", ss_pin_oe, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule